// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for every beat of a four-beat burst. A load cycle captures the whole external address. Each following advance cycle steps the two lowest address bits to the next beat position. The upper bits stay where the load put them.

Two orders are available for the low pair. Linear order counts up modulo four. Interleaved order flips bits by XOR-ing the start value with a beat counter. A mode strap selects the order, and the block takes the strap's value only when it loads. An active-low clock enable stalls the sequencer: while it is high, the address does not change.

The address is read from registers, so a load or advance taking effect at a rising edge shows at the output right after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until the first enabled edge, `addr_out` is all zeros.
- R2: At an enabled edge (`clk_en_n`=0) with `adv`=0, `addr_out` takes the full value of `ext_addr` just after that edge, and the beat count restarts at zero.
- R3: With linear order latched (`lin_mode`=1 at load), each enabled edge with `adv`=1 sets `addr_out[1:0]` to the previous low pair plus one, modulo 4. From start 2 the order is 2,3,0,1.
- R4: With interleaved order latched (`lin_mode`=0 at load), beat n shows `addr_out[1:0]` = start XOR n, with n counted modulo 4. From start 1 the order is 1,0,3,2. From start 2 it is 2,3,0,1.
- R5: On enabled edges with `adv`=1, `addr_out[AW-1:2]` keeps its loaded value, and `ext_addr` has no effect.
- R6: After four advances following a load, `addr_out` equals the loaded address again.
- R7: An edge with `clk_en_n`=1 leaves `addr_out` unchanged, whatever the values of `adv`, `ext_addr` and `lin_mode`.
- R8: A change of `lin_mode` during a burst does not change the order in use. The order changes only at the next load.
- R9: A load issued partway through a burst restarts the sequence from the newly loaded low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the block |
| adv | input | 1 | 1 = advance to the next beat, 0 = load `ext_addr` |
| ext_addr | input | AW | External address, sampled on load edges |
| lin_mode | input | 1 | Order select at load: 1 = linear, 0 = interleaved |
| addr_out | output | AW | Current internal address |

## Verification
Directed bursts from start 2 run in both orders and must produce the same sequence. Bursts from start 1 tell the orders apart, because the linear order gives 1,2,3,0 and the interleaved order gives 1,0,3,2.

Stalls are placed inside bursts, and `lin_mode` and `ext_addr` are toggled partway through bursts. These cases separate a block that ignores those inputs from one that takes them at the wrong time.

Random mixes of load, advance and stall cycles, including reloads in the middle of a burst, are compared against a bench model at every cycle. The wrap back to the loaded address after four beats is covered as well.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          adv,
  input  logic [AW-1:0] ext_addr,
  input  logic          lin_mode,
  output logic [AW-1:0] addr_out
);

  localparam int UW = AW - 2;

  logic [UW-1:0] upper_q;
  logic [1:0]    start_q;
  logic [1:0]    beat_q;
  logic          lin_q;
  logic [1:0]    low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      lin_q   <= 1'b0;
    end else if (!clk_en_n) begin
      if (!adv) begin
        upper_q <= ext_addr[AW-1:2];
        start_q <= ext_addr[1:0];
        beat_q  <= '0;
        lin_q   <= lin_mode;
      end else begin
        beat_q  <= beat_q + 2'd1;
      end
    end
  end

  assign low      = lin_q ? (start_q + beat_q) : (start_q ^ beat_q);
  assign addr_out = {upper_q, low};

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv) |=> addr_out == $past(ext_addr));

  // R5
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv) |=> $stable(addr_out[AW-1:2]));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(addr_out));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && lin_q) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

  // R4
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && !lin_q) |=>
      (addr_out[1:0] ^ $past(addr_out[1:0])) == (beat_q ^ $past(beat_q)));

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n;
  logic          adv;
  logic [AW-1:0] ext_addr;
  logic          lin_mode;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [AW-1:0] m_base;
  logic [1:0]    m_step;
  logic          m_lin;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv(adv),
    .ext_addr(ext_addr), .lin_mode(lin_mode), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] base, logic [1:0] n, logic lin);
    logic [1:0] s;
    s = base[1:0];
    return {base[AW-1:2], lin ? 2'(s + n) : 2'(s ^ n)};
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    n_chk++;
    if (addr_out !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic cyc(logic en_n, logic a, logic [AW-1:0] ad, logic lm, string req);
    clk_en_n = en_n; adv = a; ext_addr = ad; lin_mode = lm;
    @(posedge clk);
    if (!en_n) begin
      if (!a) begin m_base = ad; m_step = 2'd0; m_lin = lm; end
      else m_step = m_step + 2'd1;
    end
    @(negedge clk);
    check(req, expect_addr(m_base, m_step, m_lin));
  endtask

  task automatic burst(logic [AW-1:0] ad, logic lm, string req);
    cyc(1'b0, 1'b0, ad, lm, "R2");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, $urandom, $urandom, req);
    cyc(1'b0, 1'b1, $urandom, $urandom, "R6");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    m_base = '0; m_step = 2'd0; m_lin = 1'b0;
    rst_n = 1'b0; clk_en_n = 1'b0; adv = 1'b0; ext_addr = '1; lin_mode = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, '1, 1'b1, "R1");

    burst(21'h0A5A6, 1'b1, "R3");
    burst(21'h0A5A6, 1'b0, "R4");
    burst(21'h13371, 1'b1, "R3");
    burst(21'h13371, 1'b0, "R4");
    burst(21'h1FFFF, 1'b1, "R5");

    cyc(1'b0, 1'b0, 21'h00441, 1'b0, "R2");
    cyc(1'b0, 1'b1, 21'h1FFFF, 1'b1, "R8");
    cyc(1'b1, 1'b0, 21'h0BEEF, 1'b1, "R7");
    cyc(1'b1, 1'b1, 21'h0BEEF, 1'b1, "R7");
    cyc(1'b0, 1'b1, 21'h0, 1'b1, "R8");
    cyc(1'b0, 1'b0, 21'h0C003, 1'b1, "R9");
    cyc(1'b0, 1'b1, 21'h0, 1'b0, "R9");
    cyc(1'b0, 1'b1, 21'h0, 1'b0, "R3");

    for (int k = 0; k < 2000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0)      cyc(1'b1, $urandom, $urandom, $urandom, "R7");
      else if (r < 3)  cyc(1'b0, 1'b0, $urandom, $urandom, "R9");
      else             cyc(1'b0, 1'b1, $urandom, $urandom, m_lin ? "R3" : "R4");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule